// File: doc/BRIEF.md
# Credit-Based DMA Channel Flow Controller

This block sits on the DMA side of a multi-channel streaming path into a peripheral that holds one FIFO per channel. The peripheral gives no level or request signal; it only pulses once for every word it takes out of a channel's FIFO. The controller therefore keeps its own count of free FIFO words per channel, seeded from a programmed copy of that channel's FIFO depth, and decides from that count alone when a burst may be sent.

Software programs, per channel, the FIFO depth and a burst length, both in words and independent of each other, and enables the channel when a cyclic stream starts and disables it when the stream stops. Whenever a channel holds at least one burst's worth of credit, it becomes eligible; eligible channels are served in rotating order, one burst at a time, toward the memory-side data mover. When the mover reports that the burst is finished, the controller acknowledges it for that channel. A depth programmed larger than the real FIFO lets the controller overrun the peripheral, and a smaller one leaves free space unused and starves it, so the programmed depth must match the hardware.

Top module: `cdf_flow_ctrl`

## Requirements
- R1: After reset, `burst_start` and `burst_ack` are all zero and no burst is issued until a channel is enabled.
- R2: A channel whose enable bit is low never issues a burst; while disabled its credit is held at its programmed FIFO depth and its consume pulses have no effect.
- R3: On enable a channel's credit equals its FIFO depth (field `fifo_words[i*W +: W]`), and issuing a burst lowers the credit by the burst length (field `burst_words[i*W +: W]`); with no consume pulses a channel issues exactly floor(depth/burst) bursts.
- R4: Each cycle in which `consume[i]` is high raises channel i's credit by one word.
- R5: Credit never exceeds the programmed FIFO depth; consume pulses that would take it above the depth are dropped.
- R6: When a consume pulse and a burst issue for the same channel fall in the same cycle, the credit changes by the net amount (plus one, minus the burst length).
- R7: `burst_start` is a one-cycle pulse with at most one bit set (bit i for channel i); among eligible channels the one after the last served channel, in ascending index order with wrap-around, is chosen, starting from channel 0 after reset.
- R8: Only one burst is outstanding: after a `burst_start` pulse no further pulse occurs until `mover_done` has been seen, and in the cycle after `mover_done` is sampled high, `burst_ack` pulses with the bit of the channel that was started.
- R9: A channel with a burst length of zero, or with a burst length above its FIFO depth, never issues a burst, while other channels with their own burst lengths proceed.
- R10: Disabling and re-enabling a channel restores its credit to the full FIFO depth, so a restarted stream again issues floor(depth/burst) bursts without any consume pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | N | Per-channel stream enable |
| fifo_words | input | N*W | Per-channel peripheral FIFO depth in words, channel i at bits i*W +: W |
| burst_words | input | N*W | Per-channel burst length in words, channel i at bits i*W +: W |
| consume | input | N | Per-channel one-word consume pulse from the peripheral |
| mover_done | input | 1 | Data mover has finished the outstanding burst |
| burst_start | output | N | One-hot pulse starting a burst for the channel |
| burst_ack | output | N | One-hot pulse acknowledging completion of the channel's burst |

## Verification
A channel is first run with no consume pulses, which separates correct seeding and debiting from any stray credit, and then with short and long trains of back-to-back consume pulses: the short train shows single-word crediting, and the long train forces a burst issue into a cycle that also carries a consume, so a design that loses either the debit or the pulse issues a different number of bursts. A surplus of consume pulses delivered while the mover is held busy distinguishes saturation at the depth from an unbounded count. All four channels enabled at once reveal the service order, and zero or oversized burst lengths next to a working channel, followed by a disable and re-enable, show that eligibility and the credit reload are per channel.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_BUSY = 1'b1
  } xfer_state_e;

endpackage

// File: rtl/cdf_credit.sv
module cdf_credit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] depth,
  input  logic [W-1:0] burst,
  input  logic         take,
  input  logic         consume,
  output logic         eligible
);

  logic [W-1:0] cred_q, cred_d;
  logic         cred_ce;
  logic         en_q;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, cred_q} + {{W{1'b0}}, consume};
    if (take) begin
      sum = sum - {1'b0, burst};
    end
    if (!en || !en_q) begin
      cred_d = depth;
    end else if (sum > {1'b0, depth}) begin
      cred_d = depth;
    end else begin
      cred_d = sum[W-1:0];
    end
    cred_ce = (cred_d != cred_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cred_q <= '0;
    end else if (cred_ce) begin
      cred_q <= cred_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_q != en) begin
      en_q <= en;
    end
  end

  assign eligible = en && en_q && (burst != '0) && (cred_q >= burst);

endmodule

// File: rtl/cdf_rr_arb.sv
module cdf_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, last_d;
  logic          found;

  always_comb begin
    gnt    = '0;
    last_d = last_q;
    found  = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (!found && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        last_d   = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (adv) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/cdf_flow_ctrl.sv
module cdf_flow_ctrl #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   ch_en,
  input  logic [N*W-1:0] fifo_words,
  input  logic [N*W-1:0] burst_words,
  input  logic [N-1:0]   consume,
  input  logic           mover_done,
  output logic [N-1:0]   burst_start,
  output logic [N-1:0]   burst_ack
);

  import cdf_pkg::*;

  xfer_state_e st_q, st_d;
  logic [N-1:0] cur_q, cur_d;
  logic [N-1:0] start_q, start_d;
  logic [N-1:0] ack_q, ack_d;
  logic [N-1:0] elig;
  logic [N-1:0] gnt;
  logic [N-1:0] take;
  logic         idle;
  logic         arb_adv;

  for (genvar g = 0; g < N; g++) begin : g_ch
    cdf_credit #(.W(W)) u_cred (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[g]),
      .depth    (fifo_words[g*W +: W]),
      .burst    (burst_words[g*W +: W]),
      .take     (take[g]),
      .consume  (consume[g]),
      .eligible (elig[g])
    );
  end

  cdf_rr_arb #(.N(N)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .adv   (arb_adv),
    .gnt   (gnt)
  );

  assign idle    = (st_q == XS_IDLE);
  assign arb_adv = idle && (|elig);
  assign take    = idle ? gnt : '0;

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    start_d = '0;
    ack_d   = '0;
    if (idle) begin
      if (|gnt) begin
        st_d    = XS_BUSY;
        cur_d   = gnt;
        start_d = gnt;
      end
    end else if (mover_done) begin
      st_d  = XS_IDLE;
      ack_d = cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= XS_IDLE;
      cur_q   <= '0;
      start_q <= '0;
      ack_q   <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      ack_q   <= ack_d;
      if (idle) begin
        cur_q <= cur_d;
      end
    end
  end

  assign burst_start = start_q;
  assign burst_ack   = ack_q;

endmodule

// File: rtl/cdf_flow_ctrl_chk.sv
module cdf_flow_ctrl_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   ch_en,
  input logic [N*W-1:0] fifo_words,
  input logic [N*W-1:0] burst_words,
  input logic [N-1:0]   consume,
  input logic           mover_done,
  input logic [N-1:0]   burst_start,
  input logic [N-1:0]   burst_ack
);

  logic         inflight_q;
  logic [N-1:0] no_burst;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      no_burst[i] = (burst_words[i*W +: W] == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
    end else if (|burst_start) begin
      inflight_q <= 1'b1;
    end else if (mover_done) begin
      inflight_q <= 1'b0;
    end
  end

  // R7
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(burst_start));

  // R8
  single_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> (burst_start == '0));

  // R8
  ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_ack != '0) |-> ($past(mover_done) && $countones(burst_ack) == 1));

  // R2
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start != '0) |-> ((burst_start & ~$past(ch_en)) == '0));

  // R9
  zero_burst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start != '0) |-> ((burst_start & $past(no_burst)) == '0));

endmodule

bind cdf_flow_ctrl cdf_flow_ctrl_chk #(.N(N), .W(W)) u_chk (.*);

// File: tb/cdf_flow_ctrl_bench.sv
`timescale 1ns/1ps
module cdf_flow_ctrl_bench;

  localparam int N = 4;
  localparam int W = 8;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   ch_en;
  logic [N*W-1:0] fifo_words;
  logic [N*W-1:0] burst_words;
  logic [N-1:0]   consume;
  logic           mover_done;
  logic [N-1:0]   burst_start;
  logic [N-1:0]   burst_ack;

  int n_chk;
  int n_fail;
  int n_start;
  int mover_lat;
  int last_ch;
  bit outstanding;
  int exp_q[$];

  cdf_flow_ctrl #(.N(N), .W(W)) u_cdf_flow_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en       (ch_en),
    .fifo_words  (fifo_words),
    .burst_words (burst_words),
    .consume     (consume),
    .mover_done  (mover_done),
    .burst_start (burst_start),
    .burst_ack   (burst_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n       = 1'b0;
    ch_en       = '0;
    fifo_words  = '0;
    burst_words = '0;
    consume     = '0;
    mover_lat   = 2;
    exp_q.delete();
    outstanding = 1'b0;
    n_start     = 0;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic setup(input int ch, input int depth, input int blen);
    fifo_words[ch*W +: W]  = W'(depth);
    burst_words[ch*W +: W] = W'(blen);
  endtask

  task automatic pulses(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1 consume[ch] = 1'b1;
    end
    @(posedge clk);
    #1 consume[ch] = 1'b0;
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (burst_start != '0) begin
        int ch;
        ch = 0;
        for (int i = 0; i < N; i++) if (burst_start[i]) ch = i;
        n_start++;
        check($countones(burst_start) == 1, "R7 start one-hot", $countones(burst_start), 1);
        check(!outstanding, "R8 start while outstanding", int'(outstanding), 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected burst start on channel", ch, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(ch == e, "R7 burst channel", ch, e);
        end
        outstanding = 1'b1;
        last_ch     = ch;
      end
      if (burst_ack != '0) begin
        check(outstanding && burst_ack == N'(1 << last_ch), "R8 ack channel",
              int'(burst_ack), 1 << last_ch);
        outstanding = 1'b0;
      end
    end
  end

  // data mover model
  initial mover_done = 1'b0;
  always begin
    @(negedge clk);
    if (rst_n && burst_start != '0) begin
      repeat (mover_lat) @(posedge clk);
      #1 mover_done = 1'b1;
      @(posedge clk);
      #1 mover_done = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    do_reset();

    // R1: idle after reset
    check(burst_start == '0, "R1 start after reset", int'(burst_start), 0);
    check(burst_ack == '0, "R1 ack after reset", int'(burst_ack), 0);

    // R2: programmed but disabled channel, consume pulses ignored
    setup(1, 8, 4);
    pulses(1, 10);
    cycles(20);
    check(n_start == 0, "R2 starts while disabled", n_start, 0);

    // R3: depth 8, burst 4, no consume -> two bursts
    exp_q.push_back(1);
    exp_q.push_back(1);
    ch_en[1] = 1'b1;
    cycles(30);
    drained("R3 bursts from seeded credit");
    check(n_start == 2, "R3 burst count", n_start, 2);

    // R4: three pulses are not enough, the fourth is
    pulses(1, 3);
    cycles(20);
    check(n_start == 2, "R4 credit below burst", n_start, 2);
    exp_q.push_back(1);
    pulses(1, 1);
    cycles(20);
    drained("R4 single-word credit");

    // R6: eight back-to-back pulses, one coinciding with an issue
    exp_q.push_back(1);
    exp_q.push_back(1);
    pulses(1, 8);
    cycles(30);
    drained("R6 net credit on coincident issue");
    check(n_start == 5, "R6 burst count", n_start, 5);

    // R5: saturation at depth while the mover is held busy
    do_reset();
    mover_lat = 40;
    setup(2, 6, 4);
    exp_q.push_back(2);
    exp_q.push_back(2);
    ch_en[2] = 1'b1;
    cycles(3);
    pulses(2, 10);
    cycles(120);
    drained("R5 saturated credit");
    check(n_start == 2, "R5 burst count", n_start, 2);

    // R7: all channels eligible -> rotating order from channel 0
    do_reset();
    for (int c = 0; c < N; c++) setup(c, 8, 4);
    for (int r = 0; r < 2; r++) for (int c = 0; c < N; c++) exp_q.push_back(c);
    ch_en = '1;
    cycles(60);
    drained("R7 round-robin order");
    check(n_start == 2 * N, "R7 burst count", n_start, 2 * N);

    // R9: zero burst and oversize burst never start; independent burst works
    do_reset();
    setup(0, 8, 0);
    setup(3, 2, 4);
    setup(1, 4, 2);
    exp_q.push_back(1);
    exp_q.push_back(1);
    ch_en = 4'b1011;
    cycles(40);
    drained("R9 independent burst length");
    check(n_start == 2, "R9 burst count", n_start, 2);

    // R10: stop and restart reloads full credit
    ch_en[1] = 1'b0;
    cycles(5);
    exp_q.push_back(1);
    exp_q.push_back(1);
    ch_en[1] = 1'b1;
    cycles(40);
    drained("R10 credit reload on restart");
    check(n_start == 4, "R10 burst count", n_start, 4);

    summary();
    $finish;
  end

endmodule